// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a parallel NOR flash device model. Every write bus cycle carries an address and a data word. The low byte of the data word is the command opcode. The block runs the one-cycle and two-cycle command sequences. It sets which source later read cycles return: array data, identifier codes, query data, the status byte or the extended (buffer) status byte.

Commands that need real work are program, erase, buffered write, suspend, resume, lock-bit handling, configuration and protection programming. For these the block emits a start request toward a separate write state machine. That machine reports activity on a plain busy pin.

Write cycles arrive on a valid/ready channel. Start requests leave on a one-entry valid/ready channel. The two channels follow these back-pressure rules:
- While a start request waits for acceptance, the block holds the request fields steady.
- During that wait, `wr_ready` stays low, so no new write cycle is taken.
- `wr_ready` rises again in the cycle after the request is taken.

The array, identifier and query contents come in from outside on plain input ports. The block only selects among them.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the following hold:
  - Reads return `arr_rdata` with `rd_oe` all ones.
  - The sequence-error flag is clear.
  - `wr_ready` is 1 and `req_valid` is 0.
- R2: An accepted idle-state write of opcode FFh, 90h or 98h selects array, identifier or query read mode. From the next cycle on, `rd_data` follows `arr_rdata`, `id_rdata` or `qry_rdata` respectively.
- R3: Opcode 70h selects status read mode. In that mode `rd_data` is zero in bits 15:8, and bits 7:0 hold {ready, 0, err, err, 0000}, where ready is the inverse of `wsm_busy`.
- R4: `rd_oe` is 16'h0080 while status read mode is active and `wsm_busy` is 1. In every other case it is 16'hFFFF.
- R5: The sequence-error flag behaves as follows:
  - An opcode outside the defined set sets the flag and returns the decoder to idle with status read mode.
  - A second cycle that breaks its sequence has the same effect.
  - Opcode 50h clears the flag and leaves the read mode unchanged.
- R6: Block erase is 20h followed by D0h at an address in the same block (address bits above bit 16). That sequence issues request ERASE. Any other second cycle is a sequence error and issues no request.
- R7: Program is 40h or 10h, followed by any cycle. That second cycle issues request PROG with its address and its full 16-bit data.
- R8: In the idle state, B0h alone issues SUSPEND and D0h alone issues RESUME.
- R9: Lock commands start with 60h:
  - 60h then 01h issues LOCK_SET.
  - 60h then D0h issues LOCK_CLR.
  - 60h then any other byte is a sequence error.
- R10: B8h followed by any cycle issues CONFIG. C0h followed by any cycle issues PROTECT.
- R11: Buffered write runs as follows:
  - E8h selects extended status read mode, in which `rd_data` is {8'h00, ready, 7'b0}.
  - The next cycle's low byte N must be below 16. It announces N+1 data cycles, and each data cycle issues BUF_WORD.
  - A final D0h issues BUF_COMMIT.
  - N of 16 or more, or a final byte other than D0h, is a sequence error.
- R12: Bits 15:8 of `wr_data` play no part in opcode or confirm decoding.
- R13: Start requests obey the following:
  - A request stays valid with stable fields until `req_ready` is 1.
  - `wr_ready` is 0 while a request waits.
  - A request carries the address and full data of the cycle that completed the command.
  - Every request except BUF_WORD also selects status read mode.
  - `req_op` codes: PROG=0, ERASE=1, BUF_WORD=2, BUF_COMMIT=3, SUSPEND=4, RESUME=5, LOCK_SET=6, LOCK_CLR=7, CONFIG=8, PROTECT=9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write bus cycle is offered |
| wr_ready | output | 1 | Write cycle can be taken |
| wr_addr | input | 24 | Write cycle address |
| wr_data | input | 16 | Write cycle data; low byte is the opcode |
| arr_rdata | input | 16 | Array contents for the current read |
| id_rdata | input | 16 | Identifier contents for the current read |
| qry_rdata | input | 16 | Query contents for the current read |
| rd_data | output | 16 | Read data of the selected source |
| rd_oe | output | 16 | Per-bit output enable of the read data |
| wsm_busy | input | 1 | Write state machine is working |
| req_valid | output | 1 | Start request pending |
| req_ready | input | 1 | Write state machine takes the request |
| req_op | output | 4 | Request code |
| req_addr | output | 24 | Address of the completing cycle |
| req_data | output | 16 | Data of the completing cycle |

## Verification
The hardest condition to reach is a buffered-write data cycle offered while the previous BUF_WORD request still waits. Reaching it also requires that the last data cycle is counted correctly, so that the confirm byte lands in the right state. The stimulus does this by running buffered writes, and a program sequence, while `req_ready` pulses only one cycle in four. Write cycles are therefore held off for several clocks in the middle of sequences. Error sequences inside the same block are exercised too: a confirm to a foreign block, a bad count, and a bad final byte. They show that the decoder lands back in idle and that the very next opcode is decoded freshly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_PROG       = 4'd0,
    OP_ERASE      = 4'd1,
    OP_BUF_WORD   = 4'd2,
    OP_BUF_COMMIT = 4'd3,
    OP_SUSPEND    = 4'd4,
    OP_RESUME     = 4'd5,
    OP_LOCK_SET   = 4'd6,
    OP_LOCK_CLR   = 4'd7,
    OP_CONFIG     = 4'd8,
    OP_PROTECT    = 4'd9
  } fcd_op_e;

  typedef enum logic [2:0] {
    RM_ARRAY,
    RM_IDENT,
    RM_QUERY,
    RM_STATUS,
    RM_XSR
  } fcd_rmode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE_CF,
    ST_PROG_DATA,
    ST_LOCK_CF,
    ST_CFG_CODE,
    ST_PROT_DATA,
    ST_BUF_CNT,
    ST_BUF_DATA,
    ST_BUF_CF
  } fcd_state_e;

  localparam logic [7:0] OPC_ARRAY   = 8'hFF;
  localparam logic [7:0] OPC_IDENT   = 8'h90;
  localparam logic [7:0] OPC_QUERY   = 8'h98;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
  localparam logic [7:0] OPC_CLRSTS  = 8'h50;
  localparam logic [7:0] OPC_ERASE   = 8'h20;
  localparam logic [7:0] OPC_PROG_A  = 8'h40;
  localparam logic [7:0] OPC_PROG_B  = 8'h10;
  localparam logic [7:0] OPC_SUSPEND = 8'hB0;
  localparam logic [7:0] OPC_CONFIRM = 8'hD0;
  localparam logic [7:0] OPC_LOCK    = 8'h60;
  localparam logic [7:0] OPC_LOCKSET = 8'h01;
  localparam logic [7:0] OPC_CONFIG  = 8'hB8;
  localparam logic [7:0] OPC_PROTECT = 8'hC0;
  localparam logic [7:0] OPC_BUFWR   = 8'hE8;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int BLK_SHIFT = 17,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output fcd_rmode_e    rmode,
  output logic          issue,
  output fcd_op_e       issue_op,
  output logic          seq_err,
  output logic          clr_err
);

  localparam int CW = $clog2(BUF_WORDS + 1);
  localparam int BW = AW - BLK_SHIFT;

  fcd_state_e    state_q, state_d;
  fcd_rmode_e    mode_q, mode_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [CW-1:0] left_q, left_d;
  logic [7:0]    opc;
  logic [BW-1:0] wr_blk;

  assign opc    = wr_data[7:0];
  assign wr_blk = wr_addr[AW-1:BLK_SHIFT];
  assign rmode  = mode_q;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    blk_d    = blk_q;
    left_d   = left_q;
    issue    = 1'b0;
    issue_op = OP_PROG;
    seq_err  = 1'b0;
    clr_err  = 1'b0;
    if (wr_fire) begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (opc)
            OPC_ARRAY:   mode_d = RM_ARRAY;
            OPC_IDENT:   mode_d = RM_IDENT;
            OPC_QUERY:   mode_d = RM_QUERY;
            OPC_STATUS:  mode_d = RM_STATUS;
            OPC_CLRSTS:  clr_err = 1'b1;
            OPC_ERASE: begin
              state_d = ST_ERASE_CF;
              blk_d   = wr_blk;
            end
            OPC_PROG_A, OPC_PROG_B: state_d = ST_PROG_DATA;
            OPC_SUSPEND: begin
              issue    = 1'b1;
              issue_op = OP_SUSPEND;
            end
            OPC_CONFIRM: begin
              issue    = 1'b1;
              issue_op = OP_RESUME;
            end
            OPC_LOCK:    state_d = ST_LOCK_CF;
            OPC_CONFIG:  state_d = ST_CFG_CODE;
            OPC_PROTECT: state_d = ST_PROT_DATA;
            OPC_BUFWR: begin
              state_d = ST_BUF_CNT;
              mode_d  = RM_XSR;
            end
            default:     seq_err = 1'b1;
          endcase
        end
        ST_ERASE_CF: begin
          state_d = ST_IDLE;
          if (opc == OPC_CONFIRM && wr_blk == blk_q) begin
            issue    = 1'b1;
            issue_op = OP_ERASE;
          end else begin
            seq_err = 1'b1;
          end
        end
        ST_PROG_DATA: begin
          state_d  = ST_IDLE;
          issue    = 1'b1;
          issue_op = OP_PROG;
        end
        ST_LOCK_CF: begin
          state_d = ST_IDLE;
          if (opc == OPC_LOCKSET) begin
            issue    = 1'b1;
            issue_op = OP_LOCK_SET;
          end else if (opc == OPC_CONFIRM) begin
            issue    = 1'b1;
            issue_op = OP_LOCK_CLR;
          end else begin
            seq_err = 1'b1;
          end
        end
        ST_CFG_CODE: begin
          state_d  = ST_IDLE;
          issue    = 1'b1;
          issue_op = OP_CONFIG;
        end
        ST_PROT_DATA: begin
          state_d  = ST_IDLE;
          issue    = 1'b1;
          issue_op = OP_PROTECT;
        end
        ST_BUF_CNT: begin
          if (int'(opc) < BUF_WORDS) begin
            state_d = ST_BUF_DATA;
            left_d  = CW'(int'(opc) + 1);
          end else begin
            seq_err = 1'b1;
          end
        end
        ST_BUF_DATA: begin
          issue    = 1'b1;
          issue_op = OP_BUF_WORD;
          left_d   = left_q - 1'b1;
          if (left_q == CW'(1)) state_d = ST_BUF_CF;
        end
        ST_BUF_CF: begin
          state_d = ST_IDLE;
          if (opc == OPC_CONFIRM) begin
            issue    = 1'b1;
            issue_op = OP_BUF_COMMIT;
          end else begin
            seq_err = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (issue && issue_op != OP_BUF_WORD) mode_d = RM_STATUS;
      if (seq_err) begin
        state_d = ST_IDLE;
        mode_d  = RM_STATUS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= RM_ARRAY;
      blk_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      blk_q   <= blk_d;
      left_q  <= left_d;
    end
  end

  // R2: an idle-state FFh makes the next read an array read
  a_r2_ff_array: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && state_q == ST_IDLE && wr_data[7:0] == 8'hFF) |=> (rmode == RM_ARRAY));

  // R5: after a sequence error the decoder sits idle in status mode
  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (state_q == ST_IDLE && rmode == RM_STATUS));

  // R11: the remaining-word count never exceeds the buffer size
  a_r11_left_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUF_DATA) |-> (left_q != '0 && int'(left_q) <= BUF_WORDS));

endmodule

// File: rtl/fcd_req_hold.sv
module fcd_req_hold
  import fcd_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  fcd_op_e       issue_op,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          req_valid,
  input  logic          req_ready,
  output fcd_op_e       req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_op    <= OP_PROG;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_op    <= issue_op;
      req_addr  <= wr_addr;
      req_data  <= wr_data;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // R13: a waiting request is held unchanged
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data)));

  // R13: the decoder never issues over a request still waiting
  a_r13_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !req_valid);

endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_err,
  input  logic       clr_err,
  input  logic       wsm_busy,
  output logic [7:0] sts_byte,
  output logic [7:0] xsts_byte
);

  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (seq_err) err_q <= 1'b1;
    else if (clr_err) err_q <= 1'b0;
  end

  assign sts_byte  = {~wsm_busy, 1'b0, err_q, err_q, 4'b0000};
  assign xsts_byte = {~wsm_busy, 7'b0};

  // R5: an error is recorded on the next cycle
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> sts_byte[5:4] == 2'b11);

  // R5: a clear with no error leaves both flag bits low
  a_r5_err_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !seq_err) |=> sts_byte[5:4] == 2'b00);

endmodule

// File: rtl/fcd_rd_path.sv
module fcd_rd_path
  import fcd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fcd_rmode_e    rmode,
  input  logic          wsm_busy,
  input  logic [7:0]    sts_byte,
  input  logic [7:0]    xsts_byte,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] id_rdata,
  input  logic [DW-1:0] qry_rdata,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_oe
);

  localparam logic [DW-1:0] BIT7_ONLY = DW'(8'h80);

  always_comb begin
    unique case (rmode)
      RM_IDENT:  rd_data = id_rdata;
      RM_QUERY:  rd_data = qry_rdata;
      RM_STATUS: rd_data = DW'(sts_byte);
      RM_XSR:    rd_data = DW'(xsts_byte);
      default:   rd_data = arr_rdata;
    endcase
    rd_oe = (rmode == RM_STATUS && wsm_busy) ? BIT7_ONLY : '1;
  end

  // R4: a narrowed enable only ever exposes the ready bit while busy
  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe != '1) |-> (rd_oe == BIT7_ONLY && wsm_busy && rd_data[7] == 1'b0));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import fcd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int BLK_SHIFT = 17,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] id_rdata,
  input  logic [DW-1:0] qry_rdata,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_oe,
  input  logic          wsm_busy,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [3:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);

  logic       wr_fire, issue, seq_err, clr_err;
  fcd_op_e    issue_op, op_q;
  fcd_rmode_e rmode;
  logic [7:0] sts_byte, xsts_byte;

  assign wr_ready = ~req_valid;
  assign wr_fire  = wr_valid & wr_ready;
  assign req_op   = op_q;

  fcd_seq #(.AW(AW), .DW(DW), .BLK_SHIFT(BLK_SHIFT), .BUF_WORDS(BUF_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .rmode(rmode), .issue(issue), .issue_op(issue_op), .seq_err(seq_err), .clr_err(clr_err)
  );

  fcd_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_op(issue_op),
    .wr_addr(wr_addr), .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(op_q), .req_addr(req_addr), .req_data(req_data)
  );

  fcd_status u_sts (
    .clk(clk), .rst_n(rst_n), .seq_err(seq_err), .clr_err(clr_err),
    .wsm_busy(wsm_busy), .sts_byte(sts_byte), .xsts_byte(xsts_byte)
  );

  fcd_rd_path #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rmode(rmode), .wsm_busy(wsm_busy),
    .sts_byte(sts_byte), .xsts_byte(xsts_byte), .arr_rdata(arr_rdata),
    .id_rdata(id_rdata), .qry_rdata(qry_rdata), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // R13: while a request waits no write is taken
  a_r13_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !wr_ready);

  // R13: non-buffer requests leave reads in status mode
  a_r13_status_after: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_op != 4'd2) |-> (rd_data[15:8] == 8'h00 && rd_data[6] == 1'b0));

endmodule

// File: tb/tb_flash_cmd_front.sv
module tb_flash_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] arr_rdata = '0, id_rdata = '0, qry_rdata = '0;
  logic [DW-1:0] rd_data, rd_oe;
  logic wsm_busy = 1'b0;
  logic req_valid, req_ready = 1'b1;
  logic [3:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;

  flash_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .arr_rdata(arr_rdata), .id_rdata(id_rdata),
    .qry_rdata(qry_rdata), .rd_data(rd_data), .rd_oe(rd_oe), .wsm_busy(wsm_busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit stall = 1'b0;
  bit done = 1'b0;

  // reference model state (mode: 0 array 1 ident 2 query 3 status 4 xsr; st: sequence step)
  int m_mode, m_st, m_left, m_blk;
  bit m_err, m_pv;
  int m_op;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at cycle %0d", r, got, exp, cyc);
    end
  endtask

  task automatic m_issue(int op);
    m_pv = 1; m_op = op; m_addr = wr_addr; m_data = wr_data;
    if (op != 2) m_mode = 3;
  endtask

  always @(posedge clk) begin
    int c;
    bit fire, err;
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_st = 0; m_left = 0; m_blk = 0; m_err = 0; m_pv = 0;
      m_op = 0; m_addr = '0; m_data = '0;
    end else begin
      fire = wr_valid && !m_pv;
      if (m_pv && req_ready) m_pv = 0;
      if (fire) begin
        c = int'(wr_data[7:0]);
        err = 0;
        case (m_st)
          0: case (c)
               'hFF: m_mode = 0;
               'h90: m_mode = 1;
               'h98: m_mode = 2;
               'h70: m_mode = 3;
               'h50: m_err = 0;
               'h20: begin m_st = 1; m_blk = int'(wr_addr >> 17); end
               'h40, 'h10: m_st = 2;
               'hB0: m_issue(4);
               'hD0: m_issue(5);
               'h60: m_st = 3;
               'hB8: m_st = 4;
               'hC0: m_st = 5;
               'hE8: begin m_st = 6; m_mode = 4; end
               default: err = 1;
             endcase
          1: begin m_st = 0; if (c == 'hD0 && int'(wr_addr >> 17) == m_blk) m_issue(1); else err = 1; end
          2: begin m_st = 0; m_issue(0); end
          3: begin m_st = 0; if (c == 'h01) m_issue(6); else if (c == 'hD0) m_issue(7); else err = 1; end
          4: begin m_st = 0; m_issue(8); end
          5: begin m_st = 0; m_issue(9); end
          6: if (c < 16) begin m_left = c + 1; m_st = 7; end else err = 1;
          7: begin m_issue(2); m_left--; if (m_left == 0) m_st = 8; end
          8: begin m_st = 0; if (c == 'hD0) m_issue(3); else err = 1; end
          default: m_st = 0;
        endcase
        if (err) begin m_err = 1; m_st = 0; m_mode = 3; end
      end
    end
  end

  // compare every cycle, a quarter period after the falling edge
  always begin
    logic [DW-1:0] e_d, e_oe;
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      case (m_mode)
        0: e_d = arr_rdata;
        1: e_d = id_rdata;
        2: e_d = qry_rdata;
        3: e_d = {8'h00, ~wsm_busy, 1'b0, m_err, m_err, 4'b0};
        default: e_d = {8'h00, ~wsm_busy, 7'b0};
      endcase
      e_oe = (m_mode == 3 && wsm_busy) ? 16'h0080 : 16'hFFFF;
      chk(tag, {16'h0, rd_oe}, {16'h0, e_oe});
      chk(tag, {16'h0, rd_data & e_oe}, {16'h0, e_d & e_oe});
      chk(tag, {31'h0, wr_ready}, {31'h0, ~m_pv});
      chk(tag, {31'h0, req_valid}, {31'h0, m_pv});
      if (m_pv) begin
        chk(tag, {28'h0, req_op}, m_op);
        chk(tag, {8'h0, req_addr}, {8'h0, m_addr});
        chk(tag, {16'h0, req_data}, {16'h0, m_data});
      end
    end
  end

  // stimulus-side drivers, changed on the falling edge
  always @(negedge clk) begin
    arr_rdata <= 16'($urandom);
    id_rdata  <= 16'($urandom);
    qry_rdata <= 16'($urandom);
    req_ready <= stall ? (cyc % 4 == 3) : 1'b1;
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    tag = "R1";
    chk("R1", {31'h0, wr_ready}, 32'h1);
    chk("R1", {31'h0, req_valid}, 32'h0);
    chk("R1", {16'h0, rd_data}, {16'h0, arr_rdata});
    @(negedge clk);

    tag = "R2";
    wr(24'h000010, 16'h0090); idle(3);
    wr(24'h000020, 16'h0098); idle(3);
    wr(24'h000030, 16'h00FF); idle(2);

    tag = "R3";
    wr(24'h0, 16'h0070); idle(2);
    tag = "R4";
    wsm_busy = 1'b1; idle(3); wsm_busy = 1'b0; idle(2);

    tag = "R5";
    wr(24'h0, 16'h0033); idle(2);
    wsm_busy = 1'b1; idle(2); wsm_busy = 1'b0;
    wr(24'h0, 16'h0098); wr(24'h0, 16'h0050); idle(2);
    wr(24'h0, 16'h0070); idle(1);

    tag = "R6";
    wr(24'h040000, 16'h0020); wr(24'h041234, 16'h00D0); idle(3);
    wr(24'h040000, 16'h0020); wr(24'h060000, 16'h00D0); idle(2);
    wr(24'h040000, 16'h0020); wr(24'h040000, 16'h0055); idle(2);
    wr(24'h0, 16'h0050);

    tag = "R7";
    wr(24'h0, 16'h0040); wr(24'h012345, 16'hBEEF); idle(2);
    wr(24'h0, 16'h0010); wr(24'h00ABCD, 16'h1234); idle(2);

    tag = "R8";
    wr(24'h0, 16'h00B0); idle(2);
    wr(24'h0, 16'h00D0); idle(2);

    tag = "R9";
    wr(24'h0, 16'h0060); wr(24'h0A0000, 16'h0001); idle(2);
    wr(24'h0, 16'h0060); wr(24'h0, 16'h00D0); idle(2);
    wr(24'h0, 16'h0060); wr(24'h0, 16'h0077); idle(2);
    wr(24'h0, 16'h0050);

    tag = "R10";
    wr(24'h0, 16'h00B8); wr(24'h0, 16'h0003); idle(2);
    wr(24'h0, 16'h00C0); wr(24'h000080, 16'hFFFD); idle(2);

    tag = "R11";
    wr(24'h020000, 16'h00E8); wsm_busy = 1'b1; idle(2); wsm_busy = 1'b0; idle(1);
    wr(24'h020000, 16'h0002);
    wr(24'h020000, 16'h1111); wr(24'h020001, 16'h2222); wr(24'h020002, 16'h3333);
    wr(24'h020000, 16'h00D0); idle(2);
    wr(24'h020000, 16'h00E8); wr(24'h020000, 16'h0010); idle(2);
    wr(24'h020000, 16'h00E8); wr(24'h020000, 16'h0000); wr(24'h020000, 16'h4444);
    wr(24'h020000, 16'h0077); idle(2);
    wr(24'h0, 16'h0050);

    tag = "R12";
    wr(24'h0, 16'hA5FF); idle(2);
    wr(24'h0, 16'h3C90); idle(2);
    wr(24'h0, 16'h7E60); wr(24'h0, 16'hC301); idle(2);

    tag = "R13";
    stall = 1'b1;
    wr(24'h0, 16'h0040); wr(24'h000044, 16'h0F0F);
    wr(24'h030000, 16'h00E8); wr(24'h030000, 16'h0003);
    for (int i = 0; i < 4; i++) wr(24'h030000 + AW'(i), 16'h5A00 + DW'(i));
    wr(24'h030000, 16'h00D0);
    wr(24'h0, 16'h00B0);
    idle(8);
    stall = 1'b0;
    idle(3);

    finish_run();
  end
endmodule